// File: doc/BRIEF.md
# Bit-Serial Accumulating Adder

This block adds two WIDTH-bit operands one bit position per clock. The two operands sit in right-shifting registers, so the least significant bits are combined first. At every enabled clock a one-bit full adder takes the low bit of the accumulator register (x), the low bit of the addend register (y) and a stored carry. It writes the sum bit into the top of the accumulator and updates the carry. After WIDTH enabled clocks the accumulator holds the sum modulo 2^WIDTH and the carry holds the carry out.

While the addend register shifts, its top bit is filled from an external serial line. The next addend can therefore be streamed in during the same pass. The carry is a JK flip-flop driven with J = x AND y and K = NOT x AND NOT y. It is not cleared between passes, so a second pass without a clear adds the previous carry as carry-in. That allows operands wider than the registers to be chained.

The control pins are plain levels sampled on the rising clock edge, and there is no handshake. A synchronous clear has the highest priority. The parallel load of both registers comes next, and the shift enable comes last. With none of these asserted, all state holds.

Top module: `serial_acc_adder`

## Requirements
- R1: With `clr` high at a rising edge, the accumulator, the addend and the carry are all 0 after that edge, whatever `load` and `shift_en` are.
- R2: With `clr`, `load` and `shift_en` all low at a rising edge, the accumulator, the addend and the carry keep their values.
- R3: With `load` high and `clr` low, the accumulator takes `acc_load_val` and the addend takes `add_load_val`, the carry keeps its value, and `shift_en` has no effect in that cycle.
- R4: On an enabled shift, the accumulator moves right one place. Its bit WIDTH-1 receives the XOR of the old accumulator bit 0, the old addend bit 0 and the old carry.
- R5: On an enabled shift, the addend moves right one place and its bit WIDTH-1 receives `add_ser_in`. After WIDTH shifts the addend equals the word streamed in, with its bit 0 sent first.
- R6: On an enabled shift, the carry becomes 1 when both old low bits are 1, becomes 0 when both are 0, and otherwise keeps its value.
- R7: Starting from a zero carry, after WIDTH enabled shifts the accumulator holds (A+B) mod 2^WIDTH and the carry holds bit WIDTH of A+B. This includes the all-ones plus one case, which gives 0 with carry 1.
- R8: A pass started with a carry of 1 produces (A+B+1) mod 2^WIDTH, so passes can be chained.
- R9: Low cycles of `shift_en` in the middle of a pass pause it, and the final result is the same as an uninterrupted pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear of all state, highest priority |
| shift_en | input | 1 | Enables one serial add step |
| load | input | 1 | Parallel load of both registers |
| acc_load_val | input | WIDTH | Value loaded into the accumulator |
| add_load_val | input | WIDTH | Value loaded into the addend |
| add_ser_in | input | 1 | Serial fill bit for the addend top position |
| acc_q | output | WIDTH | Accumulator contents |
| add_q | output | WIDTH | Addend contents |
| carry_q | output | 1 | Stored carry |

## Verification
The hardest state to reach is a pass that begins with the carry already set. Since clear zeroes the carry, it can only come from the previous pass, and loads leave it alone. The stimulus first runs an overflowing pass such as all-ones plus one, then loads fresh operands without clearing and runs a second pass. The same sequence is also run with enable gaps scattered inside it. Meanwhile the addend streams in the next operand, so that operand refill and carry-in are checked together.

// File: rtl/sadd_pkg.sv
package sadd_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } op_e;

  // clear beats load, load beats shift
  function automatic op_e op_decode(input logic clr, input logic ld, input logic sh);
    op_e r;
    if (clr)     r = OP_CLEAR;
    else if (ld) r = OP_LOAD;
    else if (sh) r = OP_SHIFT;
    else         r = OP_HOLD;
    return r;
  endfunction

endpackage

// File: rtl/sadd_shreg.sv
module sadd_shreg
  import sadd_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  op_e              op,
  input  logic [WIDTH-1:0] par_in,
  input  logic             ser_in,
  output logic [WIDTH-1:0] q,
  output logic             ser_out
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] shifted;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      if (gi == MSB) begin : g_top
        assign shifted[gi] = ser_in;
      end else begin : g_mid
        assign shifted[gi] = q[gi+1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    case (op)
      OP_CLEAR: q <= '0;
      OP_LOAD:  q <= par_in;
      OP_SHIFT: q <= shifted;
      default:  q <= q;
    endcase
  end

  assign ser_out = q[0];

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (op == OP_CLEAR)
    (op == OP_LOAD) |=> (q == $past(par_in)));

endmodule

// File: rtl/sadd_jkff.sv
module sadd_jkff
  import sadd_pkg::*;
(
  input  logic clk,
  input  op_e  op,
  input  logic j,
  input  logic k,
  output logic q
);
  always_ff @(posedge clk) begin
    if (op == OP_CLEAR) begin
      q <= 1'b0;
    end else if (op == OP_SHIFT) begin
      case ({j, k})
        2'b10:   q <= 1'b1;
        2'b01:   q <= 1'b0;
        2'b11:   q <= ~q;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/sadd_bitslice.sv
module sadd_bitslice (
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic sum,
  output logic jset,
  output logic kreset
);
  always_comb begin
    sum    = x ^ y ^ cin;
    jset   = x & y;
    kreset = ~x & ~y;
  end
endmodule

// File: rtl/serial_acc_adder.sv
module serial_acc_adder
  import sadd_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             load,
  input  logic [WIDTH-1:0] acc_load_val,
  input  logic [WIDTH-1:0] add_load_val,
  input  logic             add_ser_in,
  output logic [WIDTH-1:0] acc_q,
  output logic [WIDTH-1:0] add_q,
  output logic             carry_q
);
  localparam int MSB = WIDTH - 1;

  op_e  op;
  logic x_bit, y_bit, sum_bit, j_in, k_in;

  assign op = op_decode(clr, load, shift_en);

  sadd_shreg #(.WIDTH(WIDTH)) u_acc (
    .clk(clk), .op(op), .par_in(acc_load_val), .ser_in(sum_bit),
    .q(acc_q), .ser_out(x_bit)
  );

  sadd_shreg #(.WIDTH(WIDTH)) u_add (
    .clk(clk), .op(op), .par_in(add_load_val), .ser_in(add_ser_in),
    .q(add_q), .ser_out(y_bit)
  );

  sadd_bitslice u_fa (
    .x(x_bit), .y(y_bit), .cin(carry_q),
    .sum(sum_bit), .jset(j_in), .kreset(k_in)
  );

  sadd_jkff u_cy (
    .clk(clk), .op(op), .j(j_in), .k(k_in), .q(carry_q)
  );

  // arms the checks once the first clear has defined the state
  logic chk_armed;
  always_ff @(posedge clk) if (clr) chk_armed <= 1'b1;

  // R1
  clear_all_chk: assert property (@(posedge clk) disable iff (!chk_armed)
    clr |=> (acc_q == '0 && add_q == '0 && carry_q == 1'b0));

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (clr || !chk_armed)
    (!load && !shift_en) |=> ($stable(acc_q) && $stable(add_q) && $stable(carry_q)));

  // R3
  load_carry_chk: assert property (@(posedge clk) disable iff (clr || !chk_armed)
    load |=> $stable(carry_q));

  // R4
  acc_sum_chk: assert property (@(posedge clk) disable iff (clr || !chk_armed)
    (shift_en && !load) |=>
      (acc_q[MSB] == ($past(acc_q[0]) ^ $past(add_q[0]) ^ $past(carry_q)))
      && (acc_q[MSB-1:0] == $past(acc_q[MSB:1])));

  // R5
  add_fill_chk: assert property (@(posedge clk) disable iff (clr || !chk_armed)
    (shift_en && !load) |=>
      (add_q[MSB] == $past(add_ser_in)) && (add_q[MSB-1:0] == $past(add_q[MSB:1])));

  // R6
  carry_maj_chk: assert property (@(posedge clk) disable iff (clr || !chk_armed)
    (shift_en && !load) |=>
      carry_q == (($past(acc_q[0]) && $past(add_q[0]))
               || ($past(acc_q[0]) && $past(carry_q))
               || ($past(add_q[0]) && $past(carry_q))));

endmodule

// File: tb/serial_acc_adder_tb.sv
module serial_acc_adder_tb;
  localparam int W = 4;
  localparam int MASK = (1 << W) - 1;

  logic clk = 1'b0;
  logic clr = 1'b1, shift_en = 1'b0, load = 1'b0, ser = 1'b0;
  logic [W-1:0] a_val = '0, b_val = '0;
  logic [W-1:0] acc_q, add_q;
  logic carry_q;

  int checks = 0, errors = 0;
  int m_acc = 0, m_add = 0, m_cy = 0;

  always #2.5 clk = ~clk;

  serial_acc_adder #(.WIDTH(W)) u_dut (
    .clk(clk), .clr(clr), .shift_en(shift_en), .load(load),
    .acc_load_val(a_val), .add_load_val(b_val), .add_ser_in(ser),
    .acc_q(acc_q), .add_q(add_q), .carry_q(carry_q)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one clock: drive, update reference, compare every output
  task automatic step(input string tag, input logic c, input logic l, input logic s,
                      input int av, input int bv, input logic si);
    int tot;
    @(negedge clk);
    clr = c; load = l; shift_en = s; a_val = av[W-1:0]; b_val = bv[W-1:0]; ser = si;
    @(posedge clk);
    if (c) begin
      m_acc = 0; m_add = 0; m_cy = 0;
    end else if (l) begin
      m_acc = av & MASK; m_add = bv & MASK;
    end else if (s) begin
      tot = (m_acc & 1) + (m_add & 1) + m_cy;
      m_acc = (m_acc >> 1) | ((tot % 2) << (W - 1));
      m_cy = tot / 2;
      m_add = (m_add >> 1) | (int'(si) << (W - 1));
    end
    #1;
    check({tag, " acc"}, int'(acc_q), m_acc);
    check({tag, " add"}, int'(add_q), m_add);
    check({tag, " carry"}, int'(carry_q), m_cy);
  endtask

  // load, then W shifts (with optional gaps); check the arithmetic result
  task automatic pass(input string tag, input int a0, input int b0, input int nxt,
                      input bit gaps);
    int cin, want;
    step("R3", 1'b0, 1'b1, 1'b1, a0, b0, 1'b0);
    cin = m_cy;
    for (int i = 0; i < W; i++) begin
      if (gaps && (i % 2 == 1)) step("R9", 1'b0, 1'b0, 1'b0, 0, 0, 1'b1);
      step(tag, 1'b0, 1'b0, 1'b1, 0, 0, nxt[i]);
    end
    want = (a0 & MASK) + (b0 & MASK) + cin;
    check({tag, " sum"}, int'(acc_q), want & MASK);
    check({tag, " cout"}, int'(carry_q), want >> W);
    check("R5 refill", int'(add_q), nxt & MASK);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL R7 watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step("R1", 1'b1, 1'b1, 1'b1, 5, 9, 1'b1);
    step("R2", 1'b0, 1'b0, 1'b0, 7, 7, 1'b1);
    step("R3", 1'b0, 1'b1, 1'b0, 10, 6, 1'b1);
    step("R2", 1'b0, 1'b0, 1'b0, 3, 3, 1'b1);
    step("R4", 1'b0, 1'b0, 1'b1, 0, 0, 1'b1);
    step("R1", 1'b1, 1'b0, 1'b1, 0, 0, 1'b0);
    // R7 all-ones plus one overflows to zero with carry out
    pass("R7", MASK, 1, 5, 1'b0);
    // R8 carry from the previous pass becomes carry-in
    pass("R8", 3, 4, 9, 1'b0);
    step("R1", 1'b1, 1'b0, 1'b0, 0, 0, 1'b0);
    for (int n = 0; n < 40; n++) begin
      int ra, rb, rn;
      ra = $urandom & MASK; rb = $urandom & MASK; rn = $urandom & MASK;
      if (n % 3 == 0) step("R1", 1'b1, 1'b0, 1'b0, 0, 0, 1'b0);
      pass((n % 3 == 0) ? "R7" : "R8", ra, rb, rn, 1'b0);
    end
    // R9 paused pass with carry-in set
    step("R1", 1'b1, 1'b0, 1'b0, 0, 0, 1'b0);
    pass("R7", MASK, MASK, 6, 1'b1);
    pass("R9", 8, 7, 11, 1'b1);
    step("R6", 1'b0, 1'b0, 1'b1, 0, 0, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule